// File: doc/BRIEF.md
# Retriggerable Pulse Stretcher

This block stretches a level input into a longer output pulse. The output goes high on the first clock edge that samples the trigger high. It stays high while the trigger is held. It then stays high for a fixed number of further clock edges once the trigger drops. If the trigger comes back before that hold interval runs out, the interval is dropped and the pulse carries on without a gap. A later fall starts a fresh, full hold.

Inside is a three-state Moore machine: idle, active and holding. A single up-counter times the holding state. A compile-time parameter chooses how that counter is controlled, and the port waveform is the same with either choice:

- **Mode 0** clears the counter whenever the machine is about to change state. It lets the counter climb to its limit and stop there.
- **Mode 1** counts only while the counter is below a limit that depends on the present state, and clears it otherwise. That limit is zero outside the holding state.

The trigger and the output are plain level signals, so there is no handshake on either side.

Top module: `retrig_hold`

## Requirements
- R1: While `rst` is high, and right after it falls, the state is idle, the timer is 0 and `hold_o` is 0.
- R2: A clock edge that samples `trig_i` high leaves `hold_o` high after that edge. `hold_o` stays high for as long as `trig_i` is sampled high.
- R3: Edge 1 is the first edge that samples `trig_i` low after a high. If `trig_i` stays low, `hold_o` stays high after edges 1 to HOLD_T-1 and goes low after edge HOLD_T.
- R4: If `trig_i` is sampled high again at any of edges 1 to HOLD_T, the hold is dropped. `hold_o` then has no low cycle, and the next fall starts a full HOLD_T-edge hold.
- R5: While `hold_o` is low and `trig_i` is sampled low, `hold_o` stays low.
- R6: The timer never goes above HOLD_T-2. The holding state counts timer values 0 to HOLD_T-2 before it returns to idle.
- R7: TIMER_MODE 0 and TIMER_MODE 1 give cycle-identical `hold_o` for any trigger sequence.
- R8: In mode 0, the timer reads 0 in the cycle after any state change. In mode 1, the timer reads 0 one cycle after any cycle spent outside the holding state. This includes a retrigger that enters the active state with a count still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| trig_i | input | 1 | Trigger level |
| hold_o | output | 1 | Stretched pulse |

## Verification
A timer that is not cleared when a retrigger starts shows up only later. The next hold after `trig_i` falls again comes out too short, and this appears within HOLD_T edges of that fall. A stuck or wrongly decoded state shows up sooner. In that case `hold_o` is wrong on the edge right after the trigger changes, or it never drops. For these reasons the sweep compares every cycle of both timer modes against an arithmetic model, and it includes retriggers at each hold position.

// File: rtl/retrig_hold_pkg.sv
package retrig_hold_pkg;
  // Gray-ordered codes keep the mode 0 state comparator narrow
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ON   = 2'b01,
    ST_HOLD = 2'b11
  } rh_state_e;
endpackage

// File: rtl/retrig_hold_next.sv
module retrig_hold_next
  import retrig_hold_pkg::*;
#(
  parameter int TW = 2,
  parameter logic [TW-1:0] LIM = '0
) (
  input  rh_state_e       cur_i,
  input  logic            trig_i,
  input  logic [TW-1:0]   t_i,
  output rh_state_e       nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    unique case (cur_i)
      ST_IDLE: if (trig_i) nxt_o = ST_ON;
      ST_ON:   if (!trig_i) nxt_o = ST_HOLD;
      ST_HOLD: begin
        if (trig_i)        nxt_o = ST_ON;
        else if (t_i == LIM) nxt_o = ST_IDLE;
      end
      default: nxt_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/retrig_hold_timer.sv
module retrig_hold_timer
  import retrig_hold_pkg::*;
#(
  parameter int TW = 2,
  parameter logic [TW-1:0] LIM = '0,
  parameter int MODE = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  rh_state_e     cur_i,
  input  rh_state_e     nxt_i,
  output logic [TW-1:0] t_o
);
  generate
    if (MODE == 0) begin : g_clear_on_change
      always_ff @(posedge clk or posedge rst) begin
        if (rst)                 t_o <= '0;
        else if (cur_i != nxt_i) t_o <= '0;
        else if (t_o != LIM)     t_o <= t_o + 1'b1;
      end

      AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cur_i != nxt_i) |=> (t_o == '0)); // R8
    end else begin : g_wrap_at_limit
      logic [TW-1:0] lim_cur;
      always_comb lim_cur = (cur_i == ST_HOLD) ? LIM : '0;

      always_ff @(posedge clk or posedge rst) begin
        if (rst)                t_o <= '0;
        else if (t_o < lim_cur) t_o <= t_o + 1'b1;
        else                    t_o <= '0;
      end

      AST_UNTIMED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cur_i != ST_HOLD) |=> (t_o == '0)); // R8
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (t_o <= LIM)); // R6
endmodule

// File: rtl/retrig_hold.sv
module retrig_hold
  import retrig_hold_pkg::*;
#(
  parameter int HOLD_T = 4,
  parameter int TIMER_MODE = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic hold_o
);
  localparam int LIM_INT = HOLD_T - 2;
  localparam int TW = (LIM_INT < 2) ? 1 : $clog2(LIM_INT + 1);
  localparam logic [TW-1:0] LIM = TW'(LIM_INT);

  rh_state_e     cur, nxt;
  logic [TW-1:0] t;

  retrig_hold_next #(.TW(TW), .LIM(LIM)) u_next (
    .cur_i(cur), .trig_i(trig_i), .t_i(t), .nxt_o(nxt)
  );

  retrig_hold_timer #(.TW(TW), .LIM(LIM), .MODE(TIMER_MODE)) u_timer (
    .clk(clk), .rst(rst), .cur_i(cur), .nxt_i(nxt), .t_o(t)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end

  always_comb hold_o = (cur != ST_IDLE);

  AST_RISE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> hold_o); // R2
  AST_QUIET_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (!hold_o && !trig_i) |=> !hold_o); // R5
  AST_DROP_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_o) |-> ($past(!trig_i) && $past(cur) == ST_HOLD)); // R3
  AST_HOLD_STARTS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_ON && !trig_i) |=> (cur == ST_HOLD && t == '0)); // R6
endmodule

// File: tb/sim_retrig_hold.sv
module sim_retrig_hold;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x = 1'b0;
  logic y0, y1;
  int   checks = 0;
  int   fails = 0;
  int   since;
  bit   retrig;

  always #10 clk = ~clk;

  retrig_hold #(.HOLD_T(T), .TIMER_MODE(0)) u0 (
    .clk(clk), .rst(rst), .trig_i(x), .hold_o(y0)
  );
  retrig_hold #(.HOLD_T(T), .TIMER_MODE(1)) u1 (
    .clk(clk), .rst(rst), .trig_i(x), .hold_o(y1)
  );

  // model: edges since the trigger was last sampled high
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      since  <= T + 1;
      retrig <= 1'b0;
    end else if (x) begin
      since <= 0;
      if (since >= 1 && since <= T - 1) retrig <= 1'b1;
    end else begin
      if (since <= T) since <= since + 1;
      if (since + 1 >= T) retrig <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic check_now();
    logic  e;
    string tag;
    e = (since < T);
    if (since == 0)      tag = "R2";
    else if (since <= T) tag = retrig ? "R4" : "R3";
    else                 tag = "R5";
    chk({tag, " mode0"}, y0, e);
    chk({tag, " mode1"}, y1, e);
    chk("R7 modes equal", y0, y1);
  endtask

  task automatic step(input logic v);
    @(negedge clk);
    check_now();
    x = v;
  endtask

  task automatic run_bits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) step(bits[i]);
  endtask

  initial begin
    #35;
    chk("R1 reset mode0", y0, 1'b0);
    chk("R1 reset mode1", y1, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", y0 | y1, 1'b0);
    // single pulse
    run_bits(16'h0001, 10);
    // long high period
    run_bits(16'h0FFF, 16);
    run_bits(16'h0000, 8);
    // retrigger mid-hold
    run_bits(16'b0000_0000_1001, 12);
    // retrigger on the last hold edge, then one edge too late
    run_bits(16'b0000_0001_0001, 12);
    run_bits(16'b0000_0010_0001, 12);
    // sweep every 10-cycle pattern, each followed by idle
    for (int p = 0; p < 1024; p++) run_bits(16'(p), 16);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    checks++;
    fails++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule